// File: doc/BRIEF.md
# Subroutine Return Unit with Shadow Restore

This block executes the return-from-subroutine instruction of a small 8-bit processor core. When it accepts an instruction word, it checks whether the word is a return. On a return it takes the most recent return address from its internal hardware stack and places it in the program counter. One bit of the opcode chooses whether the same instruction also copies the shadow values of the working register, the flag register and the bank-select register back into those registers. Any other accepted word is treated as an ordinary one-cycle instruction and moves the program counter forward by two bytes.

A return takes two instruction cycles. The pop and the optional restore happen on the clock edge that accepts the word. The cycle after that is an empty slot, during which offered instruction words are dropped. Two side ports stand in for the rest of the core. A call port pushes the address of the next instruction, jumps to a target, and copies the three registers into their shadows. A register write port loads the architectural registers, including the two program-counter latch registers that a return must leave alone.

Top module: `ret_unit`

## Requirements
- R1: While reset is asserted, and right after it, the program counter, the stack pointer, the underflow flag, the busy flag and all architectural registers read zero.
- R2: The block accepts a word when instr_valid is high and busy is low. An accepted word whose bits [15:1] equal 15'h0009 (words 16'h0012 and 16'h0013) is a return. Any other accepted word adds 2 to the program counter and leaves the stack and the registers unchanged.
- R3: An accepted return with a non-empty stack loads the most recently pushed address into the program counter and decrements the stack pointer by one, on the accepting edge.
- R4: An accepted return with bit 0 set (16'h0013) loads the working, flag and bank-select registers from their shadows on the same edge.
- R5: An accepted return with bit 0 clear (16'h0012) leaves the working, flag and bank-select registers unchanged.
- R6: A return never changes the high (8-bit) or upper (5-bit) program-counter latch registers.
- R7: busy is high for exactly one cycle after each accepted return. A word offered while busy is high is ignored: the program counter, the stack and the registers do not change.
- R8: A return accepted with an empty stack leaves the stack pointer at zero, loads zero into the program counter and sets a sticky underflow flag, which stays set until reset.
- R9: A call (call_en) pushes the current program counter plus 2, loads call_target into the program counter, and copies the working, flag and bank-select registers into their shadows. Register writes use reg_sel encoding 0 working, 1 flags (low 5 bits), 2 bank select (low 4 bits), 3 latch high, 4 latch upper (low 5 bits). Calls and writes take effect only in cycles where no word is accepted.
- R10: A call made when the stack already holds 31 entries leaves the stack unchanged, with the pointer still at 31, but it still loads call_target into the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| call_en | input | 1 | Call: push return address, jump, capture shadows |
| call_target | input | 21 | Jump target of a call |
| reg_we | input | 1 | Architectural register write enable |
| reg_sel | input | 3 | Register select for a write |
| reg_wdata | input | 8 | Register write data |
| pc | output | 21 | Program counter |
| busy | output | 1 | Second (empty) cycle of a return |
| stk_ptr | output | 5 | Number of entries on the return stack |
| stk_underflow | output | 1 | Sticky stack underflow flag |
| work_reg | output | 8 | Working register |
| flags_reg | output | 5 | Flag register |
| bank_sel | output | 4 | Bank-select register |
| pc_latch_hi | output | 8 | Program-counter latch, high byte |
| pc_latch_up | output | 5 | Program-counter latch, upper bits |

## Verification
A stack pointer that is off by one, or a stack entry written to the wrong slot, shows up as a wrong program counter on the return that reaches that entry. A damaged shadow copy shows up in the registers on the edge of the next return with the restore bit set. A busy flag that stays high too long or clears too early shows up within one cycle, because the program counter either fails to advance or moves when it should not. Since the reference model is compared on every clock, each of these faults is reported in the first cycle where the port values differ.

// File: rtl/ret_pkg.sv
package ret_pkg;
  parameter int unsigned PC_W    = 21;
  parameter int unsigned DEPTH   = 31;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned FLAG_W  = 5;
  parameter int unsigned BANK_W  = 4;
  parameter int unsigned LUP_W   = 5;
  parameter int unsigned INSTR_W = 16;

  // upper fifteen opcode bits shared by both return forms
  localparam logic [INSTR_W-2:0] RET_OPC_HI = 15'h0009;

  typedef enum logic [2:0] {
    SEL_WORK  = 3'd0,
    SEL_FLAGS = 3'd1,
    SEL_BANK  = 3'd2,
    SEL_LHI   = 3'd3,
    SEL_LUP   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ret_decode.sv
module ret_decode
  import ret_pkg::*;
#(
  parameter int unsigned IW = INSTR_W
) (
  input  logic          valid,
  input  logic [IW-1:0] word,
  input  logic          busy,
  output logic          accept,
  output logic          ret_fire,
  output logic          seq_fire,
  output logic          restore_bit
);
  logic is_ret;

  always_comb begin
    accept      = valid && !busy;
    is_ret      = (word[IW-1:1] == RET_OPC_HI);
    ret_fire    = accept && is_ret;
    seq_fire    = accept && !is_ret;
    restore_bit = word[0];
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned AW    = 21,
  parameter int unsigned DEPTH = 31,
  localparam int unsigned SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [AW-1:0]  push_data,
  input  logic           pop,
  output logic [AW-1:0]  top,
  output logic [SPW-1:0] sp,
  output logic           empty,
  output logic           underflow
);
  localparam logic [SPW-1:0] SP_FULL = SPW'(DEPTH);

  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q, sp_d;
  logic           uf_q, uf_d;
  logic           full, wr_en;

  always_comb begin
    empty = (sp_q == '0);
    full  = (sp_q == SP_FULL);
    wr_en = push && !pop && !full;
    sp_d  = sp_q;
    uf_d  = uf_q;
    if (pop) begin
      if (empty) uf_d = 1'b1;
      else       sp_d = sp_q - SPW'(1);
    end else if (wr_en) begin
      sp_d = sp_q + SPW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      uf_q <= 1'b0;
    end else begin
      sp_q <= sp_d;
      uf_q <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[sp_q] <= push_data;
  end

  always_comb begin
    top       = empty ? '0 : mem[sp_q - SPW'(1)];
    sp        = sp_q;
    underflow = uf_q;
  end

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty) |=> (sp_q == $past(sp_q) - SPW'(1)));
  // R8
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |=> uf_q);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (sp_q == SP_FULL));
endmodule

// File: rtl/ret_regfile.sv
module ret_regfile
  import ret_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned FW = FLAG_W,
  parameter int unsigned BW = BANK_W,
  parameter int unsigned UW = LUP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          capture,
  input  logic          restore,
  output logic [DW-1:0] work,
  output logic [FW-1:0] flags,
  output logic [BW-1:0] bank,
  output logic [DW-1:0] lat_hi,
  output logic [UW-1:0] lat_up
);
  logic [DW-1:0] work_q, work_d, sh_work_q, sh_work_d;
  logic [FW-1:0] flag_q, flag_d, sh_flag_q, sh_flag_d;
  logic [BW-1:0] bank_q, bank_d, sh_bank_q, sh_bank_d;
  logic [DW-1:0] lhi_q, lhi_d;
  logic [UW-1:0] lup_q, lup_d;

  always_comb begin
    work_d    = work_q;
    flag_d    = flag_q;
    bank_d    = bank_q;
    lhi_d     = lhi_q;
    lup_d     = lup_q;
    sh_work_d = sh_work_q;
    sh_flag_d = sh_flag_q;
    sh_bank_d = sh_bank_q;
    if (capture) begin
      sh_work_d = work_q;
      sh_flag_d = flag_q;
      sh_bank_d = bank_q;
    end
    if (restore) begin
      work_d = sh_work_q;
      flag_d = sh_flag_q;
      bank_d = sh_bank_q;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_WORK:  work_d = wr_data;
        SEL_FLAGS: flag_d = wr_data[FW-1:0];
        SEL_BANK:  bank_d = wr_data[BW-1:0];
        SEL_LHI:   lhi_d  = wr_data;
        SEL_LUP:   lup_d  = wr_data[UW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q    <= '0;
      flag_q    <= '0;
      bank_q    <= '0;
      lhi_q     <= '0;
      lup_q     <= '0;
      sh_work_q <= '0;
      sh_flag_q <= '0;
      sh_bank_q <= '0;
    end else begin
      work_q    <= work_d;
      flag_q    <= flag_d;
      bank_q    <= bank_d;
      lhi_q     <= lhi_d;
      lup_q     <= lup_d;
      sh_work_q <= sh_work_d;
      sh_flag_q <= sh_flag_d;
      sh_bank_q <= sh_bank_d;
    end
  end

  always_comb begin
    work   = work_q;
    flags  = flag_q;
    bank   = bank_q;
    lat_hi = lhi_q;
    lat_up = lup_q;
  end

  // R4
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (work_q == $past(sh_work_q) && flag_q == $past(sh_flag_q)
                 && bank_q == $past(sh_bank_q)));
  // R6
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> ($stable(lhi_q) && $stable(lup_q)));
endmodule

// File: rtl/ret_unit.sv
module ret_unit
  import ret_pkg::*;
#(
  parameter int unsigned AW  = PC_W,
  parameter int unsigned DEP = DEPTH,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned FW  = FLAG_W,
  parameter int unsigned BW  = BANK_W,
  parameter int unsigned UW  = LUP_W,
  localparam int unsigned SPW = $clog2(DEP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  input  logic [15:0]    instr_word,
  input  logic           call_en,
  input  logic [AW-1:0]  call_target,
  input  logic           reg_we,
  input  logic [2:0]     reg_sel,
  input  logic [DW-1:0]  reg_wdata,
  output logic [AW-1:0]  pc,
  output logic           busy,
  output logic [SPW-1:0] stk_ptr,
  output logic           stk_underflow,
  output logic [DW-1:0]  work_reg,
  output logic [FW-1:0]  flags_reg,
  output logic [BW-1:0]  bank_sel,
  output logic [DW-1:0]  pc_latch_hi,
  output logic [UW-1:0]  pc_latch_up
);
  logic           accept, ret_fire, seq_fire, restore_bit;
  logic           side_ok, push_en, wr_ok, restore;
  logic [AW-1:0]  pc_q, pc_d, next_seq, stk_top;
  logic           busy_q, busy_d;
  logic           stk_empty;

  ret_decode #(.IW(16)) u_dec (
    .valid       (instr_valid),
    .word        (instr_word),
    .busy        (busy_q),
    .accept      (accept),
    .ret_fire    (ret_fire),
    .seq_fire    (seq_fire),
    .restore_bit (restore_bit)
  );

  always_comb begin
    side_ok  = !accept;
    push_en  = call_en && side_ok;
    wr_ok    = reg_we && side_ok;
    restore  = ret_fire && restore_bit;
    next_seq = pc_q + AW'(2);
  end

  ret_stack #(.AW(AW), .DEPTH(DEP)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_en),
    .push_data (next_seq),
    .pop       (ret_fire),
    .top       (stk_top),
    .sp        (stk_ptr),
    .empty     (stk_empty),
    .underflow (stk_underflow)
  );

  ret_regfile #(.DW(DW), .FW(FW), .BW(BW), .UW(UW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ok),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .capture (push_en),
    .restore (restore),
    .work    (work_reg),
    .flags   (flags_reg),
    .bank    (bank_sel),
    .lat_hi  (pc_latch_hi),
    .lat_up  (pc_latch_up)
  );

  always_comb begin
    pc_d   = pc_q;
    busy_d = ret_fire;
    if (ret_fire)      pc_d = stk_empty ? '0 : stk_top;
    else if (seq_fire) pc_d = next_seq;
    else if (push_en)  pc_d = call_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    pc   = pc_q;
    busy = busy_q;
  end

  // R7
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !call_en) |=> ($stable(pc_q) && $stable(stk_ptr)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && stk_empty) |=> (pc_q == '0 && stk_underflow && stk_ptr == '0));
  // R5
  no_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !restore_bit) |=> ($stable(work_reg) && $stable(flags_reg)
                                    && $stable(bank_sel)));
  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fire |=> (pc_q == $past(pc_q) + AW'(2) && $stable(stk_ptr)));
endmodule

// File: tb/sim_ret_unit.sv
`timescale 1ns/1ps
module sim_ret_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        call_en;
  logic [20:0] call_target;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [20:0] pc;
  logic        busy;
  logic [4:0]  stk_ptr;
  logic        stk_underflow;
  logic [7:0]  work_reg;
  logic [4:0]  flags_reg;
  logic [3:0]  bank_sel;
  logic [7:0]  pc_latch_hi;
  logic [4:0]  pc_latch_up;

  ret_unit u0 (.*);

  always #2.5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // reference model state
  logic [20:0] m_pc;
  logic [20:0] m_stk[$];
  bit          m_uf, m_busy;
  logic [7:0]  m_w, m_sw, m_lhi;
  logic [4:0]  m_f, m_sf, m_lup;
  logic [3:0]  m_b, m_sb;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("pc", 32'(pc), 32'(m_pc));
    chk("busy", 32'(busy), 32'(m_busy));
    chk("sp", 32'(stk_ptr), 32'(m_stk.size()));
    chk("underflow", 32'(stk_underflow), 32'(m_uf));
    chk("work", 32'(work_reg), 32'(m_w));
    chk("flags", 32'(flags_reg), 32'(m_f));
    chk("bank", 32'(bank_sel), 32'(m_b));
    chk("latch_hi", 32'(pc_latch_hi), 32'(m_lhi));
    chk("latch_up", 32'(pc_latch_up), 32'(m_lup));
  endtask

  task automatic model_reset();
    m_pc = '0; m_stk.delete(); m_uf = 0; m_busy = 0;
    m_w = '0; m_f = '0; m_b = '0; m_sw = '0; m_sf = '0; m_sb = '0;
    m_lhi = '0; m_lup = '0;
  endtask

  task automatic step(input logic iv, input logic [15:0] iw, input logic ce,
                      input logic [20:0] ct, input logic we, input logic [2:0] sel,
                      input logic [7:0] wd);
    bit acc;
    instr_valid = iv; instr_word = iw; call_en = ce; call_target = ct;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    acc = iv && !m_busy;
    if (acc) begin
      if (iw[15:1] == 15'h0009) begin
        if (m_stk.size() == 0) begin m_uf = 1; m_pc = '0; end
        else m_pc = m_stk.pop_back();
        if (iw[0]) begin m_w = m_sw; m_f = m_sf; m_b = m_sb; end
        m_busy = 1;
      end else begin
        m_pc = m_pc + 21'd2;
        m_busy = 0;
      end
    end else begin
      m_busy = 0;
      if (ce) begin
        if (m_stk.size() < 31) m_stk.push_back(m_pc + 21'd2);
        m_sw = m_w; m_sf = m_f; m_sb = m_b;
        m_pc = ct;
      end
      if (we) begin
        case (sel)
          3'd0: m_w = wd;
          3'd1: m_f = wd[4:0];
          3'd2: m_b = wd[3:0];
          3'd3: m_lhi = wd;
          3'd4: m_lup = wd[4:0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic idle();                       step(0, 16'h0, 0, '0, 0, 3'd0, 8'h0); endtask
  task automatic instr(input logic [15:0] w);  step(1, w, 0, '0, 0, 3'd0, 8'h0);     endtask
  task automatic call(input logic [20:0] t);   step(0, 16'h0, 1, t, 0, 3'd0, 8'h0);  endtask
  task automatic wr(input logic [2:0] s, input logic [7:0] d); step(0, 16'h0, 0, '0, 1, s, d); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; instr_valid = 0; instr_word = '0; call_en = 0; call_target = '0;
    reg_we = 0; reg_sel = '0; reg_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    idle();

    cur_req = "R9";
    wr(3'd0, 8'hA5); wr(3'd1, 8'hFF); wr(3'd2, 8'h3C); wr(3'd3, 8'h5A); wr(3'd4, 8'h13);
    call(21'h000100);
    wr(3'd0, 8'h11); wr(3'd1, 8'h02); wr(3'd2, 8'h07);
    // call and write alongside an accepted word are ignored
    step(1, 16'h0000, 1, 21'h1ABCD, 1, 3'd0, 8'hEE);

    cur_req = "R5";
    instr(16'h0012);
    cur_req = "R7";
    idle();

    cur_req = "R4";
    call(21'h002000);
    wr(3'd0, 8'h99); wr(3'd1, 8'h0F); wr(3'd2, 8'h01);
    instr(16'h0013);
    idle();

    cur_req = "R2";
    instr(16'h0011); instr(16'h0014); instr(16'h8012); instr(16'h0010); instr(16'h0002);

    cur_req = "R7";
    call(21'h003000); call(21'h004000);
    instr(16'h0013);
    instr(16'h0013);   // offered while busy: ignored
    instr(16'h0012);

    cur_req = "R6";
    wr(3'd3, 8'hC3); wr(3'd4, 8'h1E);
    call(21'h005000);
    instr(16'h0013);
    idle();

    cur_req = "R10";
    for (int i = 0; i < 33; i++) call(21'(32'h10000 + i * 16));

    cur_req = "R3";
    for (int i = 0; i < 31; i++) begin instr(16'h0012); idle(); end

    cur_req = "R8";
    instr(16'h0013);
    idle();
    call(21'h00ABC);
    instr(16'h0012);
    idle();
    instr(16'h0012);
    idle();

    cur_req = "R1";
    rst_n = 0;
    model_reset();
    @(negedge clk);
    compare();
    rst_n = 1;
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule